// File: doc/BRIEF.md
# DDR3 Current-Measurement Loop Sequencer

This block replays fixed, cycle-exact command loops that hold a DDR3 device in a known current-draw state while it is measured. A two-bit mode input, captured when the loop starts, selects one of four loops. Two are active loops: activate-precharge, and activate-read-precharge. The other two are idle loops: precharge power-down and quiet standby. Each clock cycle the block drives the clock-enable and command strobes, the bank address, the row/column address, the data mask and on-die termination. It also raises a flag on the first cycle of every pass through the bank rotation.

The active loops use one row cycle of 33 clocks per ACTIVATE. PRECHARGE follows 24 clocks after the ACTIVATE, which leaves 9 clocks of precharge time. In the read loop a READ with burst 8 is issued 9 clocks after the ACTIVATE. Only one bank is open at a time. Each bank is visited for two consecutive row cycles, and the sequence wraps back to bank 0 after the last bank. The cycles between commands are deselects, and two filler encodings alternate on them so that the command and address buses partly toggle. A stop request is honoured only once the current row cycle has completed, so no bank is ever left open.

Top module: `meas_loop_seq`

## Requirements
- R1: After reset, and whenever the loop is stopped, cke_o=1, {cs_n,ras_n,cas_n,we_n}=4'b1111, ba_o=0, addr_o=0 and iter_start_o=0.
- R2: A start_i pulse while stopped starts the loop. The cycle after the sampling edge is row-cycle offset 0, which carries bank 0 and row 0. A start_i pulse while the loop runs has no effect.
- R3: In modes 0 (activate-precharge) and 1 (activate-read-precharge), ACTIVATE {0,0,1,1} appears at offset 0 of every 33-cycle row cycle, and PRECHARGE {0,0,1,0} with addr_o=0 appears at offset 24.
- R4: In mode 1, READ {0,1,0,1} with addr_o=0 appears at offset 9. In mode 0, offset 9 is a filler cycle.
- R5: In the active modes every other offset is a filler cycle with cs_n high. Even offsets give {1,0,0,0} with addr_o=0, and odd offsets give {1,1,1,1} with addr_o all ones. ba_o shows the current bank on every cycle.
- R6: Banks are visited in the order 0,0,1,1,…,N-1,N-1 and then wrap to 0. The ACTIVATE row address is all zeros on the first visit to a bank and all ones on the second.
- R7: iter_start_o is high for exactly one cycle, at offset 0 of the first visit to bank 0, at start and at each wrap of the rotation.
- R8: In mode 2 (power-down) cke_o=0, cs_n=1, ras_n=cas_n=we_n=0, ba_o=0 and addr_o=0.
- R9: In mode 3 (quiet standby) cke_o=1, cs_n=1, ras_n=cas_n=we_n=0, ba_o=0 and addr_o=0.
- R10: A stop_i pulse at any offset ends the loop after offset 32 of the current row cycle, and the stopped state of R1 follows. A later start begins again at bank 0, first visit.
- R11: mode_i is sampled only at start. Changing it while the loop runs has no effect on the outputs.
- R12: dm_o and odt_o are 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start the loop (when stopped) |
| stop_i | input | 1 | Request stop at the end of the row cycle |
| mode_i | input | 2 | Loop select: 0 act-pre, 1 act-rd-pre, 2 power-down, 3 quiet standby |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | $clog2(NUM_BANKS) | Bank address |
| addr_o | output | ADDR_W | Row/column address |
| dm_o | output | 1 | Data mask |
| odt_o | output | 1 | On-die termination |
| iter_start_o | output | 1 | First cycle of a rotation pass |

## Verification
The bench builds the block with NUM_BANKS=4, so a full rotation of eight row cycles (264 clocks) ends within one test. That brings the wrap back to bank 0, the second-visit row inversion and the repeated iteration flag within reach. The timing parameters stay at 33/24/9, so every command offset is checked at its real position. ADDR_W stays at 14, which exercises the all-ones filler address at full width.

// File: rtl/meas_loop_pkg.sv
package meas_loop_pkg;
  typedef enum logic [1:0] {
    LOOP_ACT_PRE    = 2'd0,
    LOOP_ACT_RD_PRE = 2'd1,
    LOOP_PWR_DOWN   = 2'd2,
    LOOP_QUIET      = 2'd3
  } loop_mode_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_ACT  = 4'b0011;
  localparam logic [3:0] CMD_RD   = 4'b0101;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_DES  = 4'b1111;
  localparam logic [3:0] CMD_FILL = 4'b1000;
endpackage

// File: rtl/loop_timer.sv
module loop_timer #(
  parameter int ROW_CYC = 33,
  localparam int CYC_W  = $clog2(ROW_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CYC_W-1:0] cyc_o,
  output logic             last_o
);
  assign last_o = (cyc_o == CYC_W'(ROW_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cyc_o <= '0;
    else if (!run_i || last_o)  cyc_o <= '0;
    else                        cyc_o <= cyc_o + 1'b1;
  end
endmodule

// File: rtl/bank_rotor.sv
module bank_rotor #(
  parameter int NUM_BANKS = 8,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            step_i,
  output logic [BA_W-1:0] bank_o,
  output logic            visit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o  <= '0;
      visit_o <= 1'b0;
    end else if (!run_i) begin
      bank_o  <= '0;
      visit_o <= 1'b0;
    end else if (step_i) begin
      visit_o <= ~visit_o;
      if (visit_o)
        bank_o <= (bank_o == BA_W'(NUM_BANKS - 1)) ? '0 : bank_o + 1'b1;
    end
  end
endmodule

// File: rtl/cmd_gen.sv
module cmd_gen
  import meas_loop_pkg::*;
#(
  parameter int ROW_CYC   = 33,
  parameter int ACT_RD    = 9,
  parameter int ACT_PRE   = 24,
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 14,
  localparam int CYC_W    = $clog2(ROW_CYC),
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic              run_i,
  input  loop_mode_e        mode_i,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic              visit_i,
  output logic              cke_o,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              iter_o
);
  always_comb begin
    cke_o  = 1'b1;
    cmd_o  = CMD_DES;
    ba_o   = '0;
    addr_o = '0;
    iter_o = 1'b0;
    if (run_i) begin
      iter_o = (cyc_i == '0) && (bank_i == '0) && !visit_i;
      case (mode_i)
        LOOP_PWR_DOWN: begin
          cke_o = 1'b0;
          cmd_o = CMD_FILL;
        end
        LOOP_QUIET: cmd_o = CMD_FILL;
        default: begin
          ba_o = bank_i;
          if (cyc_i == '0) begin
            cmd_o  = CMD_ACT;
            addr_o = {ADDR_W{visit_i}};  // second visit inverts row
          end else if (cyc_i == CYC_W'(ACT_PRE)) begin
            cmd_o = CMD_PRE;
          end else if (mode_i == LOOP_ACT_RD_PRE && cyc_i == CYC_W'(ACT_RD)) begin
            cmd_o = CMD_RD;
          end else if (cyc_i[0]) begin
            cmd_o  = CMD_DES;
            addr_o = '1;
          end else begin
            cmd_o = CMD_FILL;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/meas_loop_seq.sv
module meas_loop_seq
  import meas_loop_pkg::*;
#(
  parameter int ROW_CYC   = 33,
  parameter int ACT_RD    = 9,
  parameter int ACT_PRE   = 24,
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 14,
  localparam int CYC_W    = $clog2(ROW_CYC),
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        mode_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dm_o,
  output logic              odt_o,
  output logic              iter_start_o
);
  logic             run_q, stop_pend_q;
  loop_mode_e       mode_q;
  logic [CYC_W-1:0] cyc;
  logic             last;
  logic [BA_W-1:0]  bank;
  logic             visit;
  logic [3:0]       cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      mode_q      <= LOOP_ACT_PRE;
    end else if (!run_q) begin
      stop_pend_q <= 1'b0;
      if (start_i) begin
        run_q  <= 1'b1;
        mode_q <= loop_mode_e'(mode_i);
      end
    end else if (last && (stop_pend_q || stop_i)) begin
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (stop_i) begin
      stop_pend_q <= 1'b1;
    end
  end

  loop_timer #(.ROW_CYC(ROW_CYC)) i_timer (
    .clk_i, .rst_ni, .run_i(run_q), .cyc_o(cyc), .last_o(last)
  );

  bank_rotor #(.NUM_BANKS(NUM_BANKS)) i_rotor (
    .clk_i, .rst_ni, .run_i(run_q), .step_i(last), .bank_o(bank), .visit_o(visit)
  );

  cmd_gen #(
    .ROW_CYC(ROW_CYC), .ACT_RD(ACT_RD), .ACT_PRE(ACT_PRE),
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
  ) i_gen (
    .run_i(run_q), .mode_i(mode_q), .cyc_i(cyc), .bank_i(bank), .visit_i(visit),
    .cke_o, .cmd_o(cmd), .ba_o, .addr_o, .iter_o(iter_start_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign dm_o  = 1'b0;
  assign odt_o = 1'b0;
endmodule

// File: rtl/meas_loop_seq_chk.sv
module meas_loop_seq_chk
  import meas_loop_pkg::*;
#(
  parameter int ROW_CYC = 33,
  parameter int ACT_RD  = 9,
  parameter int ACT_PRE = 24,
  localparam int SW     = $clog2(ROW_CYC + 1) + 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cke_o,
  input logic cs_n_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o,
  input logic iter_start_o
);
  logic [3:0]    cmd;
  logic          is_act, is_rd, is_pre;
  logic [SW-1:0] since;  // 0: no ACT seen yet; else cycles since last ACT (saturating)

  assign cmd    = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_act = (cmd == CMD_ACT);
  assign is_rd  = (cmd == CMD_RD);
  assign is_pre = (cmd == CMD_PRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               since <= '0;
    else if (is_act)                           since <= SW'(1);
    else if (since != '0 && since != '1)       since <= since + 1'b1;
  end

  // R3
  act_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act && since != '0) |-> (since >= SW'(ROW_CYC)));
  // R3
  pre_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> (since == SW'(ACT_PRE)));
  // R4
  rd_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd |-> (since == SW'(ACT_RD)));
  // R7
  iter_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_start_o |=> !iter_start_o);
  // R8
  pd_quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (cs_n_o && !ras_n_o && !cas_n_o && !we_n_o));
endmodule

bind meas_loop_seq meas_loop_seq_chk #(
  .ROW_CYC(ROW_CYC), .ACT_RD(ACT_RD), .ACT_PRE(ACT_PRE)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_o(cke_o), .cs_n_o(cs_n_o),
  .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
  .iter_start_o(iter_start_o)
);

// File: tb/test_meas_loop_seq.sv
`timescale 1ns/1ps
module test_meas_loop_seq;
  localparam int T_RC  = 33;
  localparam int T_RD  = 9;
  localparam int T_PRE = 24;
  localparam int NB    = 4;
  localparam int AW    = 14;
  localparam int BW    = $clog2(NB);
  localparam int OW    = 1 + 4 + BW + AW + 3;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, dm_o, odt_o, iter_start_o;
  logic [BW-1:0] ba_o;
  logic [AW-1:0] addr_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  meas_loop_seq #(.ROW_CYC(T_RC), .ACT_RD(T_RD), .ACT_PRE(T_PRE),
                  .NUM_BANKS(NB), .ADDR_W(AW)) i_meas_loop_seq (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .mode_i, .cke_o, .cs_n_o,
    .ras_n_o, .cas_n_o, .we_n_o, .ba_o, .addr_o, .dm_o, .odt_o, .iter_start_o);

  function automatic logic [OW-1:0] obs();
    return {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ba_o, addr_o,
            iter_start_o, dm_o, odt_o};
  endfunction

  function automatic logic [OW-1:0] exp_vec(int mode, int c, int bank, int visit, bit run);
    logic cke = 1'b1; logic [3:0] cmd = 4'b1111; logic [BW-1:0] ba = '0;
    logic [AW-1:0] a = '0; logic it = 1'b0;
    if (run) begin
      it = (c == 0 && bank == 0 && visit == 0);
      if (mode == 2) begin cke = 1'b0; cmd = 4'b1000; end
      else if (mode == 3) cmd = 4'b1000;
      else begin
        ba = BW'(bank);
        if (c == 0) begin cmd = 4'b0011; a = visit ? '1 : '0; end
        else if (c == T_PRE) cmd = 4'b0010;
        else if (mode == 1 && c == T_RD) cmd = 4'b0101;
        else if (c % 2 == 1) begin cmd = 4'b1111; a = '1; end
        else cmd = 4'b1000;
      end
    end
    return {cke, cmd, ba, a, it, 1'b0, 1'b0};
  endfunction

  task automatic chk(string req, logic [OW-1:0] act, logic [OW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(int n, string req);
    for (int i = 0; i < n; i++) begin
      chk(req, obs(), exp_vec(0, 0, 0, 0, 1'b0));
      @(negedge clk);
    end
  endtask

  task automatic do_start(int mode);
    mode_i = 2'(mode);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one row cycle; entered and left on a negedge at offset 0
  task automatic run_row(int mode, int bank, int visit, int stop_at, int start_at,
                         int new_mode_at, string force_tag);
    for (int c = 0; c < T_RC; c++) begin
      string tag;
      if (force_tag != "") tag = force_tag;
      else if (mode == 2) tag = "R8";
      else if (mode == 3) tag = "R9";
      else if (c == 0) tag = (bank == 0 && visit == 0) ? "R7" : "R6";
      else if (c == T_PRE) tag = "R3";
      else if (c == T_RD && mode == 1) tag = "R4";
      else tag = "R5";
      chk(tag, obs(), exp_vec(mode, c, bank, visit, 1'b1));
      if (c == stop_at) stop_i = 1'b1;
      if (c == start_at) start_i = 1'b1;
      if (c == new_mode_at) mode_i = 2'(mode ^ 1);
      @(negedge clk);
      stop_i = 1'b0;
      start_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1", obs(), exp_vec(0, 0, 0, 0, 1'b0));
    @(negedge clk);
    rst_ni = 1'b1;
    check_idle(3, "R1");
    chk("R12", {dm_o, odt_o}, '0);
  endtask

  task automatic t_act_pre();
    do_start(0);
    run_row(0, 0, 0, -1, 10, -1, "R2");   // start mid-run ignored
    for (int r = 1; r < 2 * NB; r++) run_row(0, r / 2, r % 2, -1, -1, -1, "");
    run_row(0, 0, 0, -1, -1, -1, "");      // wrap: bank 0 with flag
    run_row(0, 0, 1, 5, -1, -1, "");       // stop pending until row end
    check_idle(4, "R10");
  endtask

  task automatic t_read();
    do_start(1);
    for (int r = 0; r < 3; r++) run_row(1, r / 2, r % 2, (r == 2) ? T_RC - 1 : -1, -1, -1, "");
    check_idle(2, "R10");
    chk("R12", {dm_o, odt_o}, '0);
  endtask

  task automatic t_restart();
    do_start(0);
    run_row(0, 0, 0, 0, -1, -1, "R10");
    check_idle(2, "R10");
  endtask

  task automatic t_pwr_down();
    do_start(2);
    run_row(2, 0, 0, -1, -1, 3, "");
    run_row(2, 0, 1, -1, -1, -1, "R11");   // mode_i changed, loop unchanged
    run_row(2, 1, 0, 20, -1, -1, "R8");
    check_idle(2, "R10");
  endtask

  task automatic t_quiet();
    do_start(3);
    run_row(3, 0, 0, 1, -1, -1, "");
    check_idle(2, "R10");
    do_start(1);
    run_row(1, 0, 0, -1, -1, 4, "R11");     // mode_i flips to 0, read stays
    run_row(1, 0, 1, 0, -1, -1, "R4");
    check_idle(1, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_act_pre();
    t_read();
    t_restart();
    t_pwr_down();
    t_quiet();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule